// File: doc/BRIEF.md
# Processor Bus Cycle Classifier

This block sits on the system side of a processor bus. It watches for the start of each bus cycle and classifies the cycle from the signals the processor drives with its address strobe. It then follows the cycle to completion by counting ready strobes. Downstream logic such as a memory controller, an I/O bridge or an interrupt controller reads the class, the burst flag and the current transfer index. It uses the one-cycle done pulse to close its own bookkeeping.

Burst length is settled by both sides. The processor asks for a four-transfer burst with its active-low cache request. A write burst always runs the full length. A read burst happens only if the system returns cache-enable with the first ready strobe; otherwise the read ends after one transfer. Interrupt acknowledge is treated as a pair of locked reads, and the block reports which half of the pair is in progress. All pins are plain control and status levels or pulses. No data moves through the block, so no valid/ready handshake exists and no back-pressure applies.

Top module: `bus_cycle_classifier`

## Requirements
- R1: After reset, `cyc_active`, `burst`, `cyc_done`, `proto_err`, `inta_err` and `inta_second` are 0, and `xfer_idx` is 0.
- R2: A cycle starts on a clock edge where `ads_n` is 0 and no cycle is active. From the next cycle on, `cyc_active` is 1 and `cyc_type` holds the class of the signals captured on that edge. With `mem_io`=1 and `cache_req_n`=1, the class is 0 (single memory). With `mem_io`=0 and `data_code`=1, the class is 1 (I/O), whatever the value of `cache_req_n`.
- R3: With `data_code`=0 and `mem_io`=0, the class is 3 (interrupt acknowledge) when `write_read`=0, and 4 (special) when `write_read`=1.
- R4: A memory write (`write_read`=1) with `cache_req_n`=0 has class 2 and shows `burst`=1 from its first active cycle. It needs four ready strobes, and `xfer_idx` reads 0, 1, 2, 3 before each of them.
- R5: A memory read with `cache_req_n`=0 shows class 2 and `burst`=0 until its first ready strobe. If `ken_n` is 0 with that strobe, `burst` becomes 1 and the cycle needs four ready strobes in all.
- R6: If `ken_n` is 1 with the first ready strobe of such a read, the cycle ends on that strobe and `cyc_type` changes to 0. The value of `ken_n` on any later ready strobe of a burst has no effect.
- R7: After the edge that samples the last ready strobe (`rdy_n`=0), `cyc_done` is 1 for exactly one cycle, `cyc_active` is 0 and `xfer_idx` is 0. The last strobe is the fourth for a burst and the first otherwise. `cyc_type` and `burst` keep their values until the next cycle starts.
- R8: An `ads_n`=0 sampled while a cycle is active gives a one-cycle `proto_err` pulse and is otherwise ignored: type, index and the remaining transfer count are unchanged.
- R9: `inta_second` is 0 during the first interrupt-acknowledge cycle of a pair and 1 during the second.
- R10: If a cycle other than interrupt acknowledge starts after the first half of a pair, `inta_err` pulses for one cycle and the pair is abandoned.
- R11: A ready strobe while no cycle is active is ignored: there is no `cyc_done` and `xfer_idx` stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ads_n | input | 1 | Address strobe, active low; marks the first clock of a cycle |
| data_code | input | 1 | 1 = data access, 0 = instruction fetch or control cycle |
| mem_io | input | 1 | 1 = memory, 0 = I/O or control cycle |
| write_read | input | 1 | 1 = write, 0 = read |
| cache_req_n | input | 1 | Processor burst request, active low |
| rdy_n | input | 1 | Transfer-complete strobe from the system, active low |
| ken_n | input | 1 | Cache-enable confirmation, active low, sampled with the first ready of a read |
| cyc_type | output | 3 | Class: 0 single memory, 1 I/O, 2 burst memory, 3 interrupt acknowledge, 4 special |
| cyc_active | output | 1 | A cycle is in progress |
| burst | output | 1 | Current or last cycle is a confirmed four-transfer burst |
| xfer_idx | output | 2 | Index of the transfer now awaiting its ready strobe |
| cyc_done | output | 1 | One-cycle pulse after the last ready strobe |
| inta_second | output | 1 | Current interrupt-acknowledge cycle is the second of its pair |
| inta_err | output | 1 | One-cycle pulse: pair broken by another cycle |
| proto_err | output | 1 | One-cycle pulse: address strobe during an active cycle |

## Verification
Each result is registered once, so it is due in the cycle after the edge that samples its stimulus. The class, active flag, `inta_second` and `inta_err` follow the edge that samples `ads_n`. The index, burst confirmation and done pulse follow the edge that samples `rdy_n`. `proto_err` follows the edge that samples the misplaced strobe. The bench drives every input on a falling edge and holds it for one full period. It reads the outputs on the next falling edge, half a period after the capturing edge, and reads the pulses again one period later to confirm that they last a single cycle.

// File: rtl/bus_cycle_pkg.sv
package bus_cycle_pkg;
  localparam int BURST_LEN = 4;
  localparam int IDX_W     = $clog2(BURST_LEN);

  typedef enum logic [2:0] {
    CLS_MEM_SINGLE = 3'd0,
    CLS_IO         = 3'd1,
    CLS_MEM_BURST  = 3'd2,
    CLS_INTA       = 3'd3,
    CLS_SPECIAL    = 3'd4
  } cyc_class_e;
endpackage

// File: rtl/cycle_decoder.sv
module cycle_decoder
  import bus_cycle_pkg::*;
(
  input  logic       data_code,
  input  logic       mem_io,
  input  logic       write_read,
  input  logic       cache_req_n,
  output cyc_class_e cls
);
  always_comb begin
    if (mem_io)
      cls = cache_req_n ? CLS_MEM_SINGLE : CLS_MEM_BURST;
    else if (data_code)
      cls = CLS_IO;
    else if (write_read)
      cls = CLS_SPECIAL;
    else
      cls = CLS_INTA;
  end
endmodule

// File: rtl/xfer_tracker.sv
module xfer_tracker
  import bus_cycle_pkg::*;
#(
  parameter int LEN = BURST_LEN,
  localparam int IW = $clog2(LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  cyc_class_e    cls,
  input  logic          wr,
  input  logic          rdy,
  input  logic          ken,
  output logic          active,
  output cyc_class_e    cyc_type,
  output logic          burst,
  output logic [IW-1:0] idx,
  output logic          done
);
  localparam logic [IW-1:0] LAST = IW'(LEN - 1);

  logic confirm_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active       <= 1'b0;
      cyc_type     <= CLS_MEM_SINGLE;
      burst        <= 1'b0;
      idx          <= '0;
      done         <= 1'b0;
      confirm_pend <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active       <= 1'b1;
        cyc_type     <= cls;
        idx          <= '0;
        burst        <= (cls == CLS_MEM_BURST) && wr;
        confirm_pend <= (cls == CLS_MEM_BURST) && !wr;
      end else if (active && rdy) begin
        if (confirm_pend) begin
          confirm_pend <= 1'b0;
          if (ken) begin
            burst <= 1'b1;
            idx   <= idx + 1'b1;
          end else begin
            cyc_type <= CLS_MEM_SINGLE;
            active   <= 1'b0;
            idx      <= '0;
            done     <= 1'b1;
          end
        end else if (burst && idx != LAST) begin
          idx <= idx + 1'b1;
        end else begin
          active <= 1'b0;
          idx    <= '0;
          done   <= 1'b1;
        end
      end
    end
  end

  // R7
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  burst_last_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rdy && burst && !start && idx == LAST) |=> (done && !active));

  // R11
  idle_ready_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start && rdy) |=> (!done && idx == '0));

  // R5
  unconfirmed_no_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    confirm_pend |-> !burst);
endmodule

// File: rtl/inta_pair_tracker.sv
module inta_pair_tracker
  import bus_cycle_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  cyc_class_e cls,
  output logic       second,
  output logic       err
);
  logic half_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_seen <= 1'b0;
      second    <= 1'b0;
      err       <= 1'b0;
    end else begin
      err <= 1'b0;
      if (start) begin
        if (cls == CLS_INTA) begin
          second    <= half_seen;
          half_seen <= !half_seen;
        end else begin
          second    <= 1'b0;
          err       <= half_seen;
          half_seen <= 1'b0;
        end
      end
    end
  end

  // R10
  inta_err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  // R9
  second_after_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(second) |-> !half_seen);
endmodule

// File: rtl/bus_cycle_classifier.sv
module bus_cycle_classifier
  import bus_cycle_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ads_n,
  input  logic             data_code,
  input  logic             mem_io,
  input  logic             write_read,
  input  logic             cache_req_n,
  input  logic             rdy_n,
  input  logic             ken_n,
  output logic [2:0]       cyc_type,
  output logic             cyc_active,
  output logic             burst,
  output logic [IDX_W-1:0] xfer_idx,
  output logic             cyc_done,
  output logic             inta_second,
  output logic             inta_err,
  output logic             proto_err
);
  cyc_class_e cls;
  cyc_class_e type_q;
  logic       start;

  assign start = !ads_n && !cyc_active;

  cycle_decoder u_dec (
    .data_code   (data_code),
    .mem_io      (mem_io),
    .write_read  (write_read),
    .cache_req_n (cache_req_n),
    .cls         (cls)
  );

  xfer_tracker #(.LEN(BURST_LEN)) u_xfer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cls      (cls),
    .wr       (write_read),
    .rdy      (!rdy_n),
    .ken      (!ken_n),
    .active   (cyc_active),
    .cyc_type (type_q),
    .burst    (burst),
    .idx      (xfer_idx),
    .done     (cyc_done)
  );

  inta_pair_tracker u_inta (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .cls    (cls),
    .second (inta_second),
    .err    (inta_err)
  );

  assign cyc_type = type_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) proto_err <= 1'b0;
    else        proto_err <= !ads_n && cyc_active;
  end

  // R8
  proto_err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_n && cyc_active) |=> proto_err);

  // R8
  proto_err_keeps_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_n && cyc_active && rdy_n) |=> $stable(cyc_type));

  // R9
  inta_second_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inta_second |-> (cyc_type == 3'd3));
endmodule

// File: tb/bus_cycle_classifier_bench.sv
module bus_cycle_classifier_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ads_n = 1'b1, data_code = 1'b0, mem_io = 1'b0, write_read = 1'b0;
  logic cache_req_n = 1'b1, rdy_n = 1'b1, ken_n = 1'b1;
  logic [2:0] cyc_type;
  logic cyc_active, burst, cyc_done, inta_second, inta_err, proto_err;
  logic [1:0] xfer_idx;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = !clk;

  bus_cycle_classifier u_bus_cycle_classifier (
    .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .data_code(data_code),
    .mem_io(mem_io), .write_read(write_read), .cache_req_n(cache_req_n),
    .rdy_n(rdy_n), .ken_n(ken_n), .cyc_type(cyc_type), .cyc_active(cyc_active),
    .burst(burst), .xfer_idx(xfer_idx), .cyc_done(cyc_done),
    .inta_second(inta_second), .inta_err(inta_err), .proto_err(proto_err)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Strobe a cycle start; returns on the falling edge after capture.
  task automatic start_cyc(bit dc, bit mio, bit wr, bit cn);
    @(negedge clk);
    ads_n = 1'b0; data_code = dc; mem_io = mio; write_read = wr; cache_req_n = cn;
    @(negedge clk);
    ads_n = 1'b1; cache_req_n = 1'b1;
  endtask

  task automatic ready(bit ken);
    rdy_n = 1'b0; ken_n = !ken;
    @(negedge clk);
    rdy_n = 1'b1; ken_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1", "active", cyc_active, 0);
    chk("R1", "burst", burst, 0);
    chk("R1", "done", cyc_done, 0);
    chk("R1", "idx", xfer_idx, 0);
    chk("R1", "errs", {proto_err, inta_err, inta_second}, 0);
  endtask

  task automatic t_mem_single();
    start_cyc(1, 1, 0, 1);
    chk("R2", "mem type", cyc_type, 0);
    chk("R2", "active", cyc_active, 1);
    ready(0);
    chk("R7", "done", cyc_done, 1);
    chk("R7", "active off", cyc_active, 0);
    @(negedge clk);
    chk("R7", "done one cycle", cyc_done, 0);
    chk("R7", "type held", cyc_type, 0);
  endtask

  task automatic t_io();
    start_cyc(1, 0, 1, 0);
    chk("R2", "io type despite cache req", cyc_type, 1);
    chk("R2", "io no burst", burst, 0);
    ready(1);
    chk("R2", "io done after one ready", cyc_done, 1);
  endtask

  task automatic t_special();
    start_cyc(0, 0, 1, 1);
    chk("R3", "special type", cyc_type, 4);
    ready(0);
    chk("R3", "special done", cyc_done, 1);
  endtask

  task automatic t_burst_write();
    start_cyc(1, 1, 1, 0);
    chk("R4", "burst type", cyc_type, 2);
    chk("R4", "burst flag", burst, 1);
    for (int i = 0; i < 4; i++) begin
      chk("R4", "idx before ready", xfer_idx, i);
      chk("R4", "no early done", cyc_done, 0);
      ready(0);
    end
    chk("R4", "done after fourth", cyc_done, 1);
    chk("R7", "idx wraps", xfer_idx, 0);
    chk("R7", "burst held", burst, 1);
  endtask

  task automatic t_burst_read_ok();
    start_cyc(1, 1, 0, 0);
    chk("R5", "read type", cyc_type, 2);
    chk("R5", "unconfirmed", burst, 0);
    ready(1);
    chk("R5", "confirmed", burst, 1);
    chk("R5", "idx 1", xfer_idx, 1);
    chk("R5", "no done", cyc_done, 0);
    ready(0);
    chk("R6", "later ken ignored", cyc_active, 1);
    ready(0);
    ready(1);
    chk("R5", "done after fourth", cyc_done, 1);
  endtask

  task automatic t_burst_read_nok();
    start_cyc(0, 1, 0, 0);
    ready(0);
    chk("R6", "single done", cyc_done, 1);
    chk("R6", "type downgraded", cyc_type, 0);
    chk("R6", "no burst", burst, 0);
  endtask

  task automatic t_proto();
    start_cyc(1, 1, 1, 0);
    ready(0);
    start_cyc(1, 0, 0, 1);
    chk("R8", "proto_err", proto_err, 1);
    chk("R8", "type kept", cyc_type, 2);
    chk("R8", "idx kept", xfer_idx, 1);
    @(negedge clk);
    chk("R8", "proto_err pulse", proto_err, 0);
    ready(0);
    ready(0);
    chk("R8", "no done yet", cyc_done, 0);
    ready(0);
    chk("R8", "four readies total", cyc_done, 1);
  endtask

  task automatic t_inta_pair();
    start_cyc(0, 0, 0, 1);
    chk("R3", "inta type", cyc_type, 3);
    chk("R9", "first half", inta_second, 0);
    ready(0);
    start_cyc(0, 0, 0, 1);
    chk("R9", "second half", inta_second, 1);
    chk("R10", "no err", inta_err, 0);
    ready(0);
  endtask

  task automatic t_inta_err();
    start_cyc(0, 0, 0, 1);
    ready(0);
    start_cyc(1, 1, 0, 1);
    chk("R10", "inta_err", inta_err, 1);
    chk("R10", "second cleared", inta_second, 0);
    @(negedge clk);
    chk("R10", "inta_err pulse", inta_err, 0);
    ready(0);
    start_cyc(0, 0, 0, 1);
    chk("R10", "pair restarted", inta_second, 0);
    ready(0);
  endtask

  task automatic t_idle_ready();
    @(negedge clk);
    ready(0);
    chk("R11", "no done idle", cyc_done, 0);
    chk("R11", "idx idle", xfer_idx, 0);
    chk("R11", "inactive", cyc_active, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mem_single();
    t_io();
    t_special();
    t_burst_write();
    t_burst_read_ok();
    t_burst_read_nok();
    t_proto();
    t_inta_pair();
    t_inta_err();
    t_idle_ready();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule